// File: doc/BRIEF.md
# Prime-Bank Strided Access Sequencer

This block turns a strided vector access into a stream of per-bank requests for a memory built from a prime number of banks (default 3), each holding a power-of-two number of words (default 8). The total word space is the product of the two (default 24 words). Because the two sizes share no common factor, every word address has exactly one (bank, in-bank word) pair. The bank is the address modulo the bank count. The in-bank word is the address modulo the bank depth, which is just the low address bits. No divider is used anywhere.

A command supplies a base address, a stride and an access count. Both the base and the stride are first reduced modulo the word space. The sequencer then presents one access per cycle. It keeps the bank number as a running residue, advancing it by the stride's residue with a single conditional subtraction. Each bank stays occupied for a fixed number of cycles after it is used. When the next access targets an occupied bank, issue stalls and holds that access until the bank frees. A one-cycle completion pulse follows the last access.

Top module: `prime_bank_interleaver`

## Requirements
- R1: While reset is low and on the first cycle after it, req_valid, stall, done and active are all 0.
- R2: For every presented access, req_bank equals req_addr modulo 3, given as a binary bank index from 0 to 2.
- R3: For every presented access, req_offset equals req_addr modulo 8, which is the low three bits of the address.
- R4: The k-th access (k from 0) has address (base + k*stride) mod 24, with base and stride reduced modulo 24 first, so inputs of 24 to 31 wrap. The first access is presented in the cycle after the start is accepted.
- R5: A command issues exactly count accesses. A count of 0 issues none and raises done in the cycle after the start.
- R6: done is a one-cycle pulse in the cycle directly after the last access. active is 1 from the cycle after the start until that last access, and falls together with done.
- R7: After an access to a bank, that bank takes no further access for the next 2 cycles. While the pending access targets an occupied bank, stall is 1, req_valid is 0 and the pending address is held.
- R8: Strides of 1, 2, 4, 8 and 16 run at one access per cycle with no stall. Strides that are multiples of 3 (including 0) run at one access every 3 cycles.
- R9: A start request while a command is active is ignored and does not change the running sequence.
- R10: Sweeping all 24 addresses gives 24 distinct (bank, offset) pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept a new command when idle |
| base | input | 5 | Starting word address |
| stride | input | 5 | Address increment between accesses |
| count | input | 6 | Number of accesses |
| req_valid | output | 1 | An access is issued this cycle |
| req_bank | output | 2 | Bank index of the pending access |
| req_offset | output | 3 | Word index inside the bank |
| req_addr | output | 5 | Word address of the pending access |
| stall | output | 1 | Pending access waits for an occupied bank |
| done | output | 1 | One-cycle pulse after the last access |
| active | output | 1 | A command is in progress |

## Verification
All request outputs are combinational from registered state. The first access is therefore due in the cycle after the edge that takes the start. Each later access, or stall, is due one cycle after the previous one. done is due one cycle after the last issue, and a count of 0 raises done one cycle after the start. The bench drives inputs on falling edges and samples every output on the following falling edge. It keeps a cycle index and a per-bank free-at cycle, so each expected issue, stall and done is tied to the exact cycle in which it must appear.

// File: rtl/pbi_pkg.sv
// Package: shared helpers for the prime-bank sequencer.
// Assumes modulus values are non-zero and fit in 32 bits.
package pbi_pkg;

    // Residue of v modulo m, folded one bit at a time from the MSB.
    // Each step keeps the partial remainder below m with one subtraction.
    function automatic logic [31:0] residue(input logic [31:0] v, input logic [31:0] m);
        logic [32:0] r;
        r = '0;
        for (int i = 31; i >= 0; i--) begin
            r = {r[31:0], v[i]};
            if (r >= {1'b0, m}) r = r - {1'b0, m};
        end
        return r[31:0];
    endfunction

endpackage

// File: rtl/pbi_modadd.sv
// Module: modular adder.
// Adds two operands that are each already below M and wraps the sum into [0, M).
// Assumes a < M and b < M, so a single conditional subtraction suffices.
module pbi_modadd #(
    parameter int M = 3,
    parameter int W = 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    logic [W:0] raw;

    // Sum with one guard bit, then subtract M once if the sum reached it.
    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        if (raw >= (W+1)'(M)) sum = W'(raw - (W+1)'(M));
        else                  sum = W'(raw);
    end
endmodule

// File: rtl/pbi_bank_timer.sv
// Module: per-bank occupancy timers.
// Each bank loads BUSY-1 when it is accessed and counts down to zero.
// A bank is free when its counter is zero. Assumes BUSY >= 1.
module pbi_bank_timer #(
    parameter int NB   = 3,
    parameter int BUSY = 3,
    parameter int BW   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic [BW-1:0] hit_bank,
    output logic [NB-1:0] busy
);
    localparam int TW = (BUSY > 1) ? $clog2(BUSY) : 1;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic [TW-1:0] cnt;

        // Reload on access, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 cnt <= '0;
            else if (hit && hit_bank == BW'(g))         cnt <= TW'(BUSY - 1);
            else if (cnt != '0)                         cnt <= cnt - 1'b1;
        end

        assign busy[g] = (cnt != '0);

        // Never grant an access to a bank whose timer is still running.
        p_no_busy_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && hit_bank == BW'(g)) |-> (cnt == '0));
    end

    // A granted bank index is always inside the bank range.
    p_bank_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (32'(hit_bank) < NB));
endmodule

// File: rtl/prime_bank_interleaver.sv
// Module: strided access sequencer for a prime-bank interleaved memory.
// Takes base/stride/count, reduces base and stride modulo the word space,
// and steps the address and its bank residue incrementally. The in-bank
// offset is the low address bits. Stalls while the target bank is busy.
// Assumes NUM_BANKS is prime and BANK_WORDS is a power of two.
module prime_bank_interleaver #(
    parameter  int NUM_BANKS   = 3,
    parameter  int BANK_WORDS  = 8,
    parameter  int BUSY_CYCLES = 3,
    parameter  int COUNT_W     = 6,
    localparam int N_WORDS     = NUM_BANKS * BANK_WORDS,
    localparam int AW          = $clog2(N_WORDS),
    localparam int BW          = $clog2(NUM_BANKS),
    localparam int OW          = $clog2(BANK_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [AW-1:0]      base,
    input  logic [AW-1:0]      stride,
    input  logic [COUNT_W-1:0] count,
    output logic               req_valid,
    output logic [BW-1:0]      req_bank,
    output logic [OW-1:0]      req_offset,
    output logic [AW-1:0]      req_addr,
    output logic               stall,
    output logic               done,
    output logic               active
);
    import pbi_pkg::*;

    logic               running;
    logic [AW-1:0]      cur_addr, stride_n, nxt_addr;
    logic [BW-1:0]      cur_bank, stride_b, nxt_bank;
    logic [COUNT_W-1:0] remain;
    logic               done_q;
    logic [NUM_BANKS-1:0] bank_busy;
    logic               blocked, issue;

    // Next address wraps modulo the word space.
    pbi_modadd #(.M(N_WORDS), .W(AW)) u_addr_step (
        .a(cur_addr), .b(stride_n), .sum(nxt_addr));

    // Next bank residue wraps modulo the bank count.
    pbi_modadd #(.M(NUM_BANKS), .W(BW)) u_bank_step (
        .a(cur_bank), .b(stride_b), .sum(nxt_bank));

    pbi_bank_timer #(.NB(NUM_BANKS), .BUSY(BUSY_CYCLES), .BW(BW)) u_timer (
        .clk(clk), .rst_n(rst_n), .hit(issue), .hit_bank(cur_bank), .busy(bank_busy));

    // Issue when active and the pending bank is free.
    always_comb begin
        blocked = bank_busy[cur_bank];
        issue   = running && !blocked;
    end

    // Command acceptance, address/residue stepping and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            cur_addr <= '0;
            cur_bank <= '0;
            stride_n <= '0;
            stride_b <= '0;
            remain   <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!running) begin
                if (start) begin
                    if (count == '0) begin
                        done_q <= 1'b1;
                    end else begin
                        running  <= 1'b1;
                        cur_addr <= AW'(residue(32'(base), 32'(N_WORDS)));
                        cur_bank <= BW'(residue(32'(base), 32'(NUM_BANKS)));
                        stride_n <= AW'(residue(32'(stride), 32'(N_WORDS)));
                        stride_b <= BW'(residue(32'(stride), 32'(NUM_BANKS)));
                        remain   <= count;
                    end
                end
            end else if (issue) begin
                cur_addr <= nxt_addr;
                cur_bank <= nxt_bank;
                remain   <= remain - 1'b1;
                if (remain == COUNT_W'(1)) begin
                    running <= 1'b0;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    assign req_valid  = issue;
    assign stall      = running && blocked;
    assign req_addr   = cur_addr;
    assign req_bank   = cur_bank;
    assign req_offset = cur_addr[OW-1:0];
    assign done       = done_q;
    assign active     = running;

    // Incremental bank residue agrees with the separately stepped address.
    p_bank_res_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (32'(req_bank) == 32'(req_addr) % NUM_BANKS));

    // Address stays inside the word space while running.
    p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (32'(cur_addr) < N_WORDS));

    // Issue and stall never coincide.
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && stall));

    // A stalled access keeps its address and remaining count.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(cur_addr) && $stable(remain)));

    // The last issue is followed by done and a return to idle.
    p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && remain == COUNT_W'(1)) |=> (done && !running));

    // done never appears while a command is running.
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !running);
endmodule

// File: tb/prime_bank_interleaver_test.sv
// Bench: sweeps base, stride and count over the default 3x8 configuration,
// predicting every issue, stall and done cycle arithmetically.
module prime_bank_interleaver_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] base = '0;
    logic [4:0] stride = '0;
    logic [5:0] count = '0;
    logic       req_valid, stall, done, active;
    logic [1:0] req_bank;
    logic [2:0] req_offset;
    logic [4:0] req_addr;

    int checks = 0;
    int failures = 0;
    int last_stalls = 0;
    int seen [24];
    bit finished_all = 0;

    always #5 clk = ~clk;

    prime_bank_interleaver uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
        .count(count), .req_valid(req_valid), .req_bank(req_bank),
        .req_offset(req_offset), .req_addr(req_addr), .stall(stall),
        .done(done), .active(active));

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one command; poke=1 pulses a second start mid-run (R9).
    task automatic run(int b, int s, int n, bit poke, bit record);
        int ea, es, k, cyc, last, fin, bk;
        int free_at [3];
        @(negedge clk);
        start = 1'b1; base = 5'(b); stride = 5'(s); count = 6'(n);
        @(negedge clk);
        start = 1'b0;
        ea = b % 24; es = s % 24; k = 0; cyc = 0; last = -1; fin = 0;
        last_stalls = 0;
        for (int i = 0; i < 3; i++) free_at[i] = 0;
        if (n != 0) last = -100;
        while (!fin && cyc < n * 3 + 6) begin
            if (poke && cyc == 1) begin
                start = 1'b1; base = 5'd5; stride = 5'd7; count = 6'd3;
            end else begin
                start = 1'b0;
            end
            if (cyc == last + 1) begin
                check("R6 done pulse", int'(done), 1);
                check("R6 active low", int'(active), 0);
                check("R5 no extra access", int'(req_valid), 0);
                fin = 1;
            end else begin
                check("R6 done low", int'(done), 0);
                check("R6 active high", int'(active), 1);
                bk = ea % 3;
                if (cyc >= free_at[bk]) begin
                    check("R4 valid", int'(req_valid), 1);
                    check("R4 address", int'(req_addr), ea);
                    check("R2 bank", int'(req_bank), bk);
                    check("R3 offset", int'(req_offset), ea % 8);
                    check("R7 no stall", int'(stall), 0);
                    if (record) seen[int'(req_bank) * 8 + int'(req_offset)]++;
                    free_at[bk] = cyc + 3;
                    k++;
                    ea = (ea + es) % 24;
                    if (k == n) last = cyc;
                end else begin
                    check("R7 stall", int'(stall), 1);
                    check("R7 valid low", int'(req_valid), 0);
                    check("R7 held address", int'(req_addr), ea);
                    last_stalls++;
                end
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check("R5 access count", k, n);
        check("R6 completed", fin, 1);
    endtask

    initial begin
        int strides [9] = '{1, 2, 4, 8, 16, 3, 0, 5, 23};
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid", int'(req_valid), 0);
        check("R1 stall", int'(stall), 0);
        check("R1 done", int'(done), 0);
        check("R1 active", int'(active), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", int'(req_valid), 0);
        check("R1 active after release", int'(active), 0);

        // R4, R7, R8: sweep every base against several strides
        for (int b = 0; b < 24; b++) begin
            foreach (strides[i]) begin
                run(b, strides[i], 7, 0, 0);
                if (strides[i] % 3 != 0 && (strides[i] & (strides[i] - 1)) == 0)
                    check("R8 pow2 stride no stall", last_stalls, 0);
                if (strides[i] % 3 == 0)
                    check("R8 same-bank stride", last_stalls, 2 * 6);
            end
        end

        // R4: wrapping of base and stride values above the word space
        run(30, 27, 9, 0, 0);
        run(24, 31, 10, 0, 0);

        // R5: zero count and the largest count
        run(4, 1, 0, 0, 0);
        run(11, 7, 63, 0, 0);

        // R9: start while running is ignored
        run(2, 4, 8, 1, 0);

        // R10: every address gives a distinct bank/offset pair
        for (int i = 0; i < 24; i++) seen[i] = 0;
        run(0, 1, 24, 0, 1);
        for (int i = 0; i < 24; i++) check("R10 unique pair", seen[i], 1);

        finished_all = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished_all) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule